// File: doc/BRIEF.md
# DMA Descriptor Chain Sequencer

This block steps a single DMA channel through a chain of transfer descriptors kept in memory. Software loads four channel registers (source address, destination address, next-descriptor pointer and control word) and then pulses a start input. While the channel runs, a separate data engine moves the data and pulses address-advance strobes, which step the source and destination registers. When the engine reports that a packet has finished, the sequencer looks at the pointer register. A zero pointer ends the chain. The channel stops and raises a one-cycle terminal-count pulse. A non-zero pointer makes the block read the next four-word descriptor through a simple request/acknowledge memory read port, using the bus master that bit 0 of the pointer selects. Once it has all four words, it resumes the channel.

A descriptor in memory is four consecutive words at a word-aligned address, in this order: source, destination, next pointer, control. The data engine must not move data while the channel-enable output is low. This covers the cycles of every descriptor fetch.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset all four channel registers read zero, and chan_en, tc_irq and mem_req are low.
- R2: A go pulse while the channel is idle raises chan_en from the next clock edge.
- R3: While chan_en is high, each src_adv or dst_adv pulse adds STEP (default 4) to the source or destination register. The destination register keeps its last value after the channel stops.
- R4: A pkt_done pulse while the pointer is non-zero drops chan_en at the next edge. It then issues exactly four reads at pointer[31:2]*4 + 0, +4, +8, +12 in that order, and mem_addr bits 1:0 are always zero.
- R5: mem_master equals bit 0 of the pointer value that launched the fetch, for all four reads.
- R6: The fetched words load the source, destination, pointer and control registers in read order. chan_en returns high at the edge that accepts the fourth word.
- R7: Bit 1 of the pointer register always reads zero, whether the value was written by software or loaded from memory. Bits 31:2 and bit 0 keep the written value.
- R8: A pkt_done pulse while the pointer is zero drops chan_en at the next edge, with tc_irq high for exactly that one cycle. No memory read is issued.
- R9: Software writes to the pointer (sw_sel=2) or control (sw_sel=3) register are ignored while the channel is not idle, and are accepted when it is idle. Register select codes are 0 source, 1 destination, 2 pointer, 3 control.
- R10: Once raised, mem_req stays high with mem_addr and mem_master unchanged until mem_ack is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start pulse, used when idle |
| sw_we | input | 1 | Software register write strobe |
| sw_sel | input | 2 | Register select: 0 src, 1 dst, 2 pointer, 3 control |
| sw_wdata | input | AW | Software write data |
| sw_rdata | output | AW | Selected register, combinational |
| src_adv | input | 1 | Engine advanced the source address |
| dst_adv | input | 1 | Engine advanced the destination address |
| pkt_done | input | 1 | Engine finished the current packet |
| chan_en | output | 1 | Channel may move data |
| tc_irq | output | 1 | One-cycle pulse when the chain ends |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | AW | Descriptor word address |
| mem_master | output | 1 | Bus master for the fetch |
| mem_ack | input | 1 | Read data valid, completes the request |
| mem_rdata | input | AW | Read data |

## Verification
Every registered result shows up at the first rising edge after the stimulus. chan_en follows go or pkt_done one edge later, a register update follows a write or advance strobe one edge later, and tc_irq is high only in the cycle after the final pkt_done. The first fetch request appears one edge after pkt_done. Each word is taken at the edge where mem_ack is high, and chan_en returns at the edge of the fourth acknowledge. Inputs are driven and outputs sampled on falling edges, so each check reads the value that the preceding rising edge produced. The memory model inserts wait cycles before each acknowledge and checks every request against a queue of expected (address, master) items.

// File: rtl/dma_chain_seq.sv
module dma_chain_seq #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          sw_we,
  input  logic [1:0]    sw_sel,
  input  logic [AW-1:0] sw_wdata,
  output logic [AW-1:0] sw_rdata,
  input  logic          src_adv,
  input  logic          dst_adv,
  input  logic          pkt_done,
  output logic          chan_en,
  output logic          tc_irq,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          mem_master,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_RUN, S_F0, S_F1, S_F2, S_F3, S_DONE} st_t;

  st_t           state;
  logic [AW-1:0] src_q, dst_q, nxt_q, ctl_q, base_q;
  logic [1:0]    fidx;
  logic          beat, last, idle;

  always_comb begin
    case (state)
      S_F1:    fidx = 2'd1;
      S_F2:    fidx = 2'd2;
      S_F3:    fidx = 2'd3;
      default: fidx = 2'd0;
    endcase
  end

  assign mem_req    = (state == S_F0) || (state == S_F1) || (state == S_F2) || (state == S_F3);
  assign mem_addr   = {base_q[AW-1:2], 2'b00} + {{(AW-4){1'b0}}, fidx, 2'b00};
  assign mem_master = base_q[0];
  assign beat       = mem_req && mem_ack;
  assign last       = (nxt_q[AW-1:2] == '0);
  assign idle       = (state == S_IDLE);
  assign chan_en    = (state == S_RUN);
  assign tc_irq     = (state == S_DONE);

  always_comb begin
    case (sw_sel)
      2'd0:    sw_rdata = src_q;
      2'd1:    sw_rdata = dst_q;
      2'd2:    sw_rdata = nxt_q;
      default: sw_rdata = ctl_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      base_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (go) state <= S_RUN;
        S_RUN:
          if (pkt_done) begin
            if (last) state <= S_DONE;
            else begin
              base_q <= nxt_q;
              state  <= S_F0;
            end
          end
        S_F0:   if (beat) state <= S_F1;
        S_F1:   if (beat) state <= S_F2;
        S_F2:   if (beat) state <= S_F3;
        S_F3:   if (beat) state <= S_RUN;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      nxt_q <= '0;
      ctl_q <= '0;
    end else begin
      if (beat && fidx == 2'd0)        src_q <= mem_rdata;
      else if (sw_we && sw_sel == 2'd0) src_q <= sw_wdata;
      else if (src_adv && chan_en)      src_q <= src_q + AW'(STEP);

      if (beat && fidx == 2'd1)        dst_q <= mem_rdata;
      else if (sw_we && sw_sel == 2'd1) dst_q <= sw_wdata;
      else if (dst_adv && chan_en)      dst_q <= dst_q + AW'(STEP);

      if (beat && fidx == 2'd2)                 nxt_q <= {mem_rdata[AW-1:2], 1'b0, mem_rdata[0]};
      else if (sw_we && sw_sel == 2'd2 && idle) nxt_q <= {sw_wdata[AW-1:2], 1'b0, sw_wdata[0]};

      if (beat && fidx == 2'd3)                 ctl_q <= mem_rdata;
      else if (sw_we && sw_sel == 2'd3 && idle) ctl_q <= sw_wdata;
    end
  end

  assert_fetch_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  assert_en_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chan_en) |-> $past(pkt_done));

  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_master));

  assert_tc_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tc_irq |=> !tc_irq);

  assert_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en && pkt_done && last |=> !chan_en && tc_irq && !mem_req);

  assert_ctl_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !idle && state != S_F3 |=> ctl_q == $past(ctl_q));

  assert_ptr_bit1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_sel == 2'd2 |-> sw_rdata[1] == 1'b0);

endmodule

// File: tb/sim_dma_chain_seq.sv
module sim_dma_chain_seq;
  logic        clk = 0, rst_n = 0;
  logic        go = 0, sw_we = 0, src_adv = 0, dst_adv = 0, pkt_done = 0, mem_ack = 0;
  logic [1:0]  sw_sel = 0;
  logic [31:0] sw_wdata = 0, mem_rdata = 0;
  logic [31:0] sw_rdata, mem_addr;
  logic        chan_en, tc_irq, mem_req, mem_master;

  dma_chain_seq u0 (.clk, .rst_n, .go, .sw_we, .sw_sel, .sw_wdata, .sw_rdata,
    .src_adv, .dst_adv, .pkt_done, .chan_en, .tc_irq, .mem_req, .mem_addr,
    .mem_master, .mem_ack, .mem_rdata);

  always #5 clk = ~clk;

  typedef struct { logic [31:0] a; logic m; } exp_t;
  exp_t q[$];
  logic [31:0] mem [0:63];
  int checks = 0, fails = 0;
  int wcnt = 0;
  logic [31:0] held_a;
  logic held_m;
  localparam int WAITS = 2;

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder and fetch monitor
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 0;
    else if (mem_req) begin
      if (wcnt == 0) begin
        if (q.size() == 0) check(0, "R8 unexpected fetch", mem_addr, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          check(mem_addr == e.a, "R4 fetch address", mem_addr, e.a);
          check(mem_master == e.m, "R5 fetch master", {31'b0, mem_master}, {31'b0, e.m});
        end
        held_a = mem_addr;
        held_m = mem_master;
      end else begin
        check(mem_addr == held_a && mem_master == held_m, "R10 request held", mem_addr, held_a);
      end
      if (wcnt == WAITS) begin
        mem_ack = 1;
        mem_rdata = mem[mem_addr[7:2]];
        wcnt = 0;
      end else wcnt++;
    end
  end

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); sw_we = 1; sw_sel = s; sw_wdata = d;
    @(negedge clk); sw_we = 0;
  endtask

  task automatic rd_chk(input logic [1:0] s, input logic [31:0] e, input string tag);
    sw_sel = s; #1;
    check(sw_rdata == e, tag, sw_rdata, e);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which) 0: go = 1; 1: src_adv = 1; 2: dst_adv = 1; default: pkt_done = 1; endcase
    @(negedge clk);
    go = 0; src_adv = 0; dst_adv = 0; pkt_done = 0;
  endtask

  task automatic push(input logic [31:0] base, input logic m);
    for (int k = 0; k < 4; k++) q.push_back('{base + 32'(4*k), m});
  endtask

  task automatic wait_en();
    for (int k = 0; k < 60 && !chan_en; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
    mem[16] = 32'h0000_1000; mem[17] = 32'h0000_2000; mem[18] = 32'h0000_0083; mem[19] = 32'hC0DE_0001;
    mem[32] = 32'h0000_3000; mem[33] = 32'h0000_4000; mem[34] = 32'h0000_0000; mem[35] = 32'h0000_BEEF;

    repeat (3) @(negedge clk);
    check(!chan_en && !tc_irq && !mem_req, "R1 outputs idle", {29'b0, chan_en, tc_irq, mem_req}, 0);
    for (int s = 0; s < 4; s++) rd_chk(2'(s), 0, "R1 register reset");
    rst_n = 1;

    wr(0, 32'h100); wr(1, 32'h200); wr(2, 32'h42); wr(3, 32'h11);
    rd_chk(2, 32'h40, "R7 pointer bit1 masked");
    wr(2, 32'h43);
    rd_chk(2, 32'h41, "R7 bit0 kept");
    wr(2, 32'h40);

    pulse(0);
    check(chan_en, "R2 enable after go", {31'b0, chan_en}, 1);

    pulse(2); pulse(2); pulse(2); pulse(1); pulse(1);
    rd_chk(1, 32'h20C, "R3 destination advance");
    rd_chk(0, 32'h108, "R3 source advance");

    wr(3, 32'hFFFF);
    rd_chk(3, 32'h11, "R9 control write ignored");
    wr(2, 32'h0);
    rd_chk(2, 32'h40, "R9 pointer write ignored");

    push(32'h40, 0);
    pulse(3);
    check(!chan_en && !tc_irq, "R4 enable drops for fetch", {30'b0, chan_en, tc_irq}, 0);
    wait_en();
    check(chan_en, "R6 enable after fourth word", {31'b0, chan_en}, 1);
    check(q.size() == 0, "R4 four reads issued", q.size(), 0);
    rd_chk(0, 32'h1000, "R6 source loaded");
    rd_chk(1, 32'h2000, "R6 destination loaded");
    rd_chk(2, 32'h81, "R7 loaded pointer bit1 masked");
    rd_chk(3, 32'hC0DE_0001, "R6 control loaded");

    push(32'h80, 1);
    pulse(3);
    wait_en();
    check(q.size() == 0, "R5 four reads on master 1", q.size(), 0);
    rd_chk(0, 32'h3000, "R6 second source");
    rd_chk(1, 32'h4000, "R6 second destination");
    rd_chk(2, 32'h0, "R6 second pointer");
    rd_chk(3, 32'hBEEF, "R6 second control");

    pulse(2); pulse(2);
    pulse(3);
    check(!chan_en && tc_irq, "R8 stop with terminal pulse", {30'b0, chan_en, tc_irq}, 1);
    @(negedge clk);
    check(!chan_en && !tc_irq && !mem_req, "R8 single pulse, no fetch", {29'b0, chan_en, tc_irq, mem_req}, 0);
    rd_chk(1, 32'h4008, "R3 destination kept after stop");
    pulse(2);
    rd_chk(1, 32'h4008, "R3 no advance while stopped");

    wr(3, 32'h55);
    rd_chk(3, 32'h55, "R9 control write accepted when idle");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule